// File: doc/BRIEF.md
# Store-Set Memory Dependence Predictor

This block tells an out-of-order core which older store a memory instruction should wait for. Instructions are grouped into dependence sets. A PC-indexed set table gives each trained PC a set number. A second table, indexed by set number, holds the sequence number of the newest store of that set still in flight. When a load is looked up, it is made to wait only on that one predicted producer store. It is not held behind every older store.

Training happens when the core finds an ordering violation. It reports the store PC and the load PC, and the block joins the two PCs into one set. Stores are announced at insert. Their tracking ends when they issue or when they are squashed. A small CAM keeps the sequence number, thread and set of each in-flight store, so that a per-thread squash can find and retire the last-store entries that belong to squashed stores. A clear input wipes both tables. The lookup path is combinational. All updates take effect on the rising clock edge.

Top module: `store_set_pred`

## Requirements
- R1: After `rst` is released, every PC reports `look_hit`=0, `look_seq`=0 and `look_set_vld`=0.
- R2: The set-table slot of a PC is `(pc >> OFFSET_BITS) & (SSIT_ENTRIES-1)`. Two PCs that differ only above those bits share one slot, and so they share one set.
- R3: On a violation where neither PC has a valid set, both PCs get set `((load_pc ^ (load_pc >> 10)) mod LFST_ENTRIES)`, and that set becomes valid.
- R4: On a violation where exactly one of the two PCs has a valid set, the other PC takes that same set.
- R5: On a violation where both PCs have valid sets, both PCs take the numerically smaller of the two sets.
- R6: A store insert whose PC has a valid set writes its sequence number as the last store of that set, and a lookup then returns it with `look_hit`=1. A store insert whose PC has no valid set changes nothing.
- R7: An insert with `ins_is_store`=0 (a load) has no effect on any lookup result.
- R8: A lookup returns `look_hit`=0 and `look_seq`=0 when the PC has no valid set, or when its set has no valid last store. The result follows `look_pc` in the same cycle, with no clock edge needed.
- R9: A store issue clears its set's last-store entry only if that entry still holds the issuing store's sequence number. An issue with any other sequence number leaves the entry unchanged.
- R10: A squash (thread T, number N) drops every tracked store of thread T whose sequence number is greater than N, and it invalidates the last-store entries that still hold those stores. Stores of other threads, and stores not younger than N, are kept.
- R11: `clear` invalidates every entry of both tables. It takes precedence over any update in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| clear | input | 1 | Invalidate both tables |
| viol_valid | input | 1 | Violation training request |
| viol_store_pc | input | PC_W | PC of the older store |
| viol_load_pc | input | PC_W | PC of the younger load |
| ins_valid | input | 1 | Instruction insert |
| ins_is_store | input | 1 | 1 for a store, 0 for a load |
| ins_pc | input | PC_W | PC of the inserted instruction |
| ins_seq | input | SEQ_W | Sequence number of the inserted instruction |
| ins_tid | input | TID_W | Thread of the inserted instruction |
| look_pc | input | PC_W | PC being looked up |
| look_hit | output | 1 | A producer store is predicted |
| look_seq | output | SEQ_W | Sequence number to wait for, 0 when none |
| look_set_vld | output | 1 | The looked-up PC has a valid set |
| look_set | output | $clog2(LFST_ENTRIES) | Set number of the looked-up PC |
| iss_valid | input | 1 | Issue notification |
| iss_is_store | input | 1 | The issuing instruction is a store |
| iss_pc | input | PC_W | PC of the issuing instruction |
| iss_seq | input | SEQ_W | Sequence number of the issuing instruction |
| sq_valid | input | 1 | Squash request |
| sq_tid | input | TID_W | Thread being squashed |
| sq_seq | input | SEQ_W | Stores younger than this number are removed |

## Verification
The assertions take the following for granted about the inputs:
- Sequence numbers are nonzero, unique and increase without wrapping, so "younger" is a plain unsigned greater-than.
- A squash never arrives in the same cycle as a store insert of the same thread.

The stimulus stays within these limits. It applies one operation per cycle and uses small, strictly increasing sequence numbers. The only deliberate overlap is a clear together with a store insert, which exercises R11.

// File: rtl/ssp_pkg.sv
package ssp_pkg;
  // Which side of a violation already carries a valid set
  typedef enum logic [1:0] {
    MRG_NONE  = 2'b00,
    MRG_LOAD  = 2'b01,
    MRG_STORE = 2'b10,
    MRG_BOTH  = 2'b11
  } merge_e;

  localparam int HASH_SHIFT = 10;
endpackage

// File: rtl/ssp_id_table.sv
module ssp_id_table #(
  parameter int PC_W    = 32,
  parameter int ENTRIES = 64,
  parameter int OFFSET  = 2,
  parameter int SET_W   = 4,
  parameter int NRD     = 3
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      clear,
  input  logic [NRD-1:0][PC_W-1:0]  rd_pc,
  output logic [NRD-1:0]            rd_vld,
  output logic [NRD-1:0][SET_W-1:0] rd_set,
  input  logic                      viol_valid,
  input  logic [PC_W-1:0]           viol_store_pc,
  input  logic [PC_W-1:0]           viol_load_pc
);
  import ssp_pkg::*;
  localparam int IDX_W = $clog2(ENTRIES);

  logic [SET_W-1:0]   set_q [ENTRIES];
  logic [ENTRIES-1:0] vld_q;

  function automatic logic [IDX_W-1:0] slot_of(input logic [PC_W-1:0] pc);
    return pc[OFFSET +: IDX_W];
  endfunction

  function automatic logic [SET_W-1:0] hash_of(input logic [PC_W-1:0] pc);
    logic [PC_W-1:0] h;
    h = pc ^ (pc >> HASH_SHIFT);
    return h[SET_W-1:0];
  endfunction

  for (genvar g = 0; g < NRD; g++) begin : g_rd
    assign rd_vld[g] = vld_q[slot_of(rd_pc[g])];
    assign rd_set[g] = set_q[slot_of(rd_pc[g])];
  end

  logic [IDX_W-1:0] s_idx, l_idx;
  logic [SET_W-1:0] s_set, l_set, new_set;
  merge_e           mcase;

  assign s_idx = slot_of(viol_store_pc);
  assign l_idx = slot_of(viol_load_pc);
  assign s_set = set_q[s_idx];
  assign l_set = set_q[l_idx];
  assign mcase = merge_e'({vld_q[s_idx], vld_q[l_idx]});

  always_comb begin
    unique case (mcase)
      MRG_NONE:  new_set = hash_of(viol_load_pc);
      MRG_LOAD:  new_set = l_set;
      MRG_STORE: new_set = s_set;
      default:   new_set = (s_set < l_set) ? s_set : l_set;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst || clear) vld_q <= '0;
    else if (viol_valid) begin
      vld_q[s_idx] <= 1'b1;
      vld_q[l_idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (viol_valid && !clear) begin
      set_q[s_idx] <= new_set;
      set_q[l_idx] <= new_set;
    end
  end

  // R3/R4/R5: after training, both PCs share one valid set
  p_viol_joins_r4: assert property (@(posedge clk) disable iff (rst)
    (viol_valid && !clear) |=> (vld_q[$past(s_idx)] && vld_q[$past(l_idx)] &&
                                set_q[$past(s_idx)] == set_q[$past(l_idx)]));
  // R11: clear empties the set table
  p_clear_ids_r11: assert property (@(posedge clk) disable iff (rst)
    clear |=> (vld_q == '0));
endmodule

// File: rtl/ssp_last_store.sv
module ssp_last_store #(
  parameter int ENTRIES = 16,
  parameter int SEQ_W   = 16,
  parameter int KILLS   = 8,
  localparam int SET_W  = $clog2(ENTRIES)
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      clear,
  input  logic [SET_W-1:0]          lk_set,
  output logic                      lk_vld,
  output logic [SEQ_W-1:0]          lk_seq,
  input  logic                      wr_en,
  input  logic [SET_W-1:0]          wr_set,
  input  logic [SEQ_W-1:0]          wr_seq,
  input  logic                      iss_en,
  input  logic [SET_W-1:0]          iss_set,
  input  logic [SEQ_W-1:0]          iss_seq,
  input  logic [KILLS-1:0]          kill_en,
  input  logic [KILLS-1:0][SET_W-1:0] kill_set,
  input  logic [KILLS-1:0][SEQ_W-1:0] kill_seq
);
  logic [SEQ_W-1:0]   seq_q [ENTRIES];
  logic [ENTRIES-1:0] vld_q, vld_n;
  logic               iss_match;

  assign lk_vld    = vld_q[lk_set];
  assign lk_seq    = seq_q[lk_set];
  assign iss_match = iss_en && vld_q[iss_set] && (seq_q[iss_set] == iss_seq);

  always_comb begin
    vld_n = vld_q;
    if (iss_match) vld_n[iss_set] = 1'b0;
    for (int e = 0; e < KILLS; e++)
      if (kill_en[e] && vld_q[kill_set[e]] && seq_q[kill_set[e]] == kill_seq[e])
        vld_n[kill_set[e]] = 1'b0;
    if (wr_en) vld_n[wr_set] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst || clear) vld_q <= '0;
    else              vld_q <= vld_n;
  end

  always_ff @(posedge clk) begin
    if (wr_en && !clear) seq_q[wr_set] <= wr_seq;
  end

  // R9: a matching issue retires the entry unless a new store lands on it
  p_issue_retires_r9: assert property (@(posedge clk) disable iff (rst)
    (iss_match && !clear && !(wr_en && wr_set == iss_set)) |=> !vld_q[$past(iss_set)]);
  // R6: a write makes the entry valid with the written number
  p_write_lands_r6: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !clear) |=> (vld_q[$past(wr_set)] && seq_q[$past(wr_set)] == $past(wr_seq)));
  // R11: clear empties the last-store table
  p_clear_last_r11: assert property (@(posedge clk) disable iff (rst)
    clear |=> (vld_q == '0));
endmodule

// File: rtl/ssp_inflight_cam.sv
module ssp_inflight_cam #(
  parameter int DEPTH = 8,
  parameter int SEQ_W = 16,
  parameter int TID_W = 2,
  parameter int SET_W = 4
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        clear,
  input  logic                        alloc_en,
  input  logic [SEQ_W-1:0]            alloc_seq,
  input  logic [TID_W-1:0]            alloc_tid,
  input  logic [SET_W-1:0]            alloc_set,
  input  logic                        rel_en,
  input  logic [SEQ_W-1:0]            rel_seq,
  input  logic                        sq_en,
  input  logic [TID_W-1:0]            sq_tid,
  input  logic [SEQ_W-1:0]            sq_seq,
  output logic [DEPTH-1:0]            kill_en,
  output logic [DEPTH-1:0][SET_W-1:0] kill_set,
  output logic [DEPTH-1:0][SEQ_W-1:0] kill_seq
);
  localparam int IDX_W = $clog2(DEPTH);

  logic [SEQ_W-1:0] seq_q [DEPTH];
  logic [TID_W-1:0] tid_q [DEPTH];
  logic [SET_W-1:0] set_q [DEPTH];
  logic [DEPTH-1:0] vld_q, vld_n;
  logic [IDX_W-1:0] free_idx;
  logic             full;

  always_comb begin
    free_idx = '0;
    full     = 1'b1;
    for (int i = DEPTH - 1; i >= 0; i--)
      if (!vld_q[i]) begin
        free_idx = IDX_W'(i);
        full     = 1'b0;
      end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_kill
    assign kill_en[g]  = sq_en && vld_q[g] && tid_q[g] == sq_tid && seq_q[g] > sq_seq;
    assign kill_set[g] = set_q[g];
    assign kill_seq[g] = seq_q[g];
  end

  always_comb begin
    vld_n = vld_q;
    for (int i = 0; i < DEPTH; i++)
      if ((rel_en && vld_q[i] && seq_q[i] == rel_seq) || kill_en[i]) vld_n[i] = 1'b0;
    if (alloc_en && !full) vld_n[free_idx] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst || clear) vld_q <= '0;
    else              vld_q <= vld_n;
  end

  always_ff @(posedge clk) begin
    if (alloc_en && !full && !clear) begin
      seq_q[free_idx] <= alloc_seq;
      tid_q[free_idx] <= alloc_tid;
      set_q[free_idx] <= alloc_set;
    end
  end

  // R10: after a squash no younger store of that thread remains
  logic             sqd_en;
  logic [TID_W-1:0] sqd_tid;
  logic [SEQ_W-1:0] sqd_seq;
  logic             young_live;

  always_ff @(posedge clk) begin
    if (rst) sqd_en <= 1'b0;
    else     sqd_en <= sq_en && !alloc_en;
    sqd_tid <= sq_tid;
    sqd_seq <= sq_seq;
  end

  always_comb begin
    young_live = 1'b0;
    for (int i = 0; i < DEPTH; i++)
      if (vld_q[i] && tid_q[i] == sqd_tid && seq_q[i] > sqd_seq) young_live = 1'b1;
  end

  p_squash_clean_r10: assert property (@(posedge clk) disable iff (rst)
    sqd_en |-> !young_live);
  // R6: a store allocation into a free slot adds exactly one tracked entry
  p_alloc_grows_r6: assert property (@(posedge clk) disable iff (rst)
    (alloc_en && !full && !rel_en && !sq_en && !clear) |=>
      ($countones(vld_q) == $past($countones(vld_q)) + 1));
endmodule

// File: rtl/store_set_pred.sv
module store_set_pred #(
  parameter int PC_W         = 32,
  parameter int SEQ_W        = 16,
  parameter int TID_W        = 2,
  parameter int SSIT_ENTRIES = 64,
  parameter int LFST_ENTRIES = 16,
  parameter int CAM_DEPTH    = 8,
  parameter int OFFSET_BITS  = 2,
  localparam int SET_W       = $clog2(LFST_ENTRIES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             viol_valid,
  input  logic [PC_W-1:0]  viol_store_pc,
  input  logic [PC_W-1:0]  viol_load_pc,
  input  logic             ins_valid,
  input  logic             ins_is_store,
  input  logic [PC_W-1:0]  ins_pc,
  input  logic [SEQ_W-1:0] ins_seq,
  input  logic [TID_W-1:0] ins_tid,
  input  logic [PC_W-1:0]  look_pc,
  output logic             look_hit,
  output logic [SEQ_W-1:0] look_seq,
  output logic             look_set_vld,
  output logic [SET_W-1:0] look_set,
  input  logic             iss_valid,
  input  logic             iss_is_store,
  input  logic [PC_W-1:0]  iss_pc,
  input  logic [SEQ_W-1:0] iss_seq,
  input  logic             sq_valid,
  input  logic [TID_W-1:0] sq_tid,
  input  logic [SEQ_W-1:0] sq_seq
);
  localparam int NRD = 3;
  localparam int RD_LOOK = 0, RD_INS = 1, RD_ISS = 2;

  logic [NRD-1:0][PC_W-1:0]  rd_pc;
  logic [NRD-1:0]            rd_vld;
  logic [NRD-1:0][SET_W-1:0] rd_set;

  assign rd_pc[RD_LOOK] = look_pc;
  assign rd_pc[RD_INS]  = ins_pc;
  assign rd_pc[RD_ISS]  = iss_pc;

  ssp_id_table #(
    .PC_W(PC_W), .ENTRIES(SSIT_ENTRIES), .OFFSET(OFFSET_BITS), .SET_W(SET_W), .NRD(NRD)
  ) u_ids (
    .clk, .rst, .clear,
    .rd_pc, .rd_vld, .rd_set,
    .viol_valid, .viol_store_pc, .viol_load_pc
  );

  logic                          st_ins, st_iss;
  logic                          lk_vld;
  logic [SEQ_W-1:0]              lk_seq;
  logic [CAM_DEPTH-1:0]            kill_en;
  logic [CAM_DEPTH-1:0][SET_W-1:0] kill_set;
  logic [CAM_DEPTH-1:0][SEQ_W-1:0] kill_seq;

  assign st_ins = ins_valid && ins_is_store && rd_vld[RD_INS];
  assign st_iss = iss_valid && iss_is_store && rd_vld[RD_ISS];

  ssp_last_store #(
    .ENTRIES(LFST_ENTRIES), .SEQ_W(SEQ_W), .KILLS(CAM_DEPTH)
  ) u_last (
    .clk, .rst, .clear,
    .lk_set(rd_set[RD_LOOK]), .lk_vld, .lk_seq,
    .wr_en(st_ins), .wr_set(rd_set[RD_INS]), .wr_seq(ins_seq),
    .iss_en(st_iss), .iss_set(rd_set[RD_ISS]), .iss_seq,
    .kill_en, .kill_set, .kill_seq
  );

  ssp_inflight_cam #(
    .DEPTH(CAM_DEPTH), .SEQ_W(SEQ_W), .TID_W(TID_W), .SET_W(SET_W)
  ) u_cam (
    .clk, .rst, .clear,
    .alloc_en(st_ins), .alloc_seq(ins_seq), .alloc_tid(ins_tid), .alloc_set(rd_set[RD_INS]),
    .rel_en(iss_valid && iss_is_store), .rel_seq(iss_seq),
    .sq_en(sq_valid), .sq_tid, .sq_seq,
    .kill_en, .kill_set, .kill_seq
  );

  assign look_set_vld = rd_vld[RD_LOOK];
  assign look_set     = rd_set[RD_LOOK];
  assign look_hit     = rd_vld[RD_LOOK] && lk_vld;
  assign look_seq     = look_hit ? lk_seq : '0;

  // R8: a prediction is never produced without a valid set
  p_hit_needs_set_r8: assert property (@(posedge clk) disable iff (rst)
    look_hit |-> (look_set_vld && look_seq != '0));
endmodule

// File: tb/tb_store_set_pred.sv
module tb_store_set_pred;
  localparam int PC_W = 32, SEQ_W = 16, TID_W = 2;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             clear = 1'b0;
  logic             viol_valid = 1'b0;
  logic [PC_W-1:0]  viol_store_pc = '0, viol_load_pc = '0;
  logic             ins_valid = 1'b0, ins_is_store = 1'b0;
  logic [PC_W-1:0]  ins_pc = '0;
  logic [SEQ_W-1:0] ins_seq = '0;
  logic [TID_W-1:0] ins_tid = '0;
  logic [PC_W-1:0]  look_pc = '0;
  logic             look_hit, look_set_vld;
  logic [SEQ_W-1:0] look_seq;
  logic [3:0]       look_set;
  logic             iss_valid = 1'b0, iss_is_store = 1'b0;
  logic [PC_W-1:0]  iss_pc = '0;
  logic [SEQ_W-1:0] iss_seq = '0;
  logic             sq_valid = 1'b0;
  logic [TID_W-1:0] sq_tid = '0;
  logic [SEQ_W-1:0] sq_seq = '0;

  int n_chk = 0, n_fail = 0;

  store_set_pred dut (.*);

  always #4 clk = ~clk;

  // PCs chosen to land on distinct set-table slots
  localparam logic [PC_W-1:0] PC_S  = 32'h0000_2008; // slot 2
  localparam logic [PC_W-1:0] PC_L  = 32'h0000_1040; // slot 16
  localparam logic [PC_W-1:0] PC_S2 = 32'h0000_3010; // slot 4
  localparam logic [PC_W-1:0] PC_L2 = 32'h0000_0500; // slot 0
  localparam logic [PC_W-1:0] PC_S3 = 32'h0000_4020; // slot 8
  localparam logic [PC_W-1:0] PC_L3 = 32'h0000_0404; // slot 1
  localparam logic [PC_W-1:0] PC_NO = 32'h0000_07F0; // slot 60, never trained

  function automatic logic [3:0] hash(input logic [PC_W-1:0] pc);
    logic [PC_W-1:0] h;
    h = pc ^ (pc >> 10);
    return h[3:0];
  endfunction

  task automatic check(input string req, input string what, input longint act, input longint exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic look(input logic [PC_W-1:0] pc, input string req, input bit hit, input int seq);
    look_pc = pc;
    #1;
    check(req, "look_hit", look_hit, hit);
    check(req, "look_seq", look_seq, seq);
  endtask

  task automatic look_id(input logic [PC_W-1:0] pc, input string req, input bit vld, input int set);
    look_pc = pc;
    #1;
    check(req, "look_set_vld", look_set_vld, vld);
    if (vld) check(req, "look_set", look_set, set);
  endtask

  task automatic train(input logic [PC_W-1:0] spc, input logic [PC_W-1:0] lpc);
    @(negedge clk);
    viol_valid = 1'b1; viol_store_pc = spc; viol_load_pc = lpc;
    @(negedge clk);
    viol_valid = 1'b0;
  endtask

  task automatic insert(input logic [PC_W-1:0] pc, input bit st, input int seq, input int tid);
    @(negedge clk);
    ins_valid = 1'b1; ins_is_store = st; ins_pc = pc; ins_seq = SEQ_W'(seq); ins_tid = TID_W'(tid);
    @(negedge clk);
    ins_valid = 1'b0;
  endtask

  task automatic issue(input logic [PC_W-1:0] pc, input int seq);
    @(negedge clk);
    iss_valid = 1'b1; iss_is_store = 1'b1; iss_pc = pc; iss_seq = SEQ_W'(seq);
    @(negedge clk);
    iss_valid = 1'b0;
  endtask

  task automatic squash(input int tid, input int seq);
    @(negedge clk);
    sq_valid = 1'b1; sq_tid = TID_W'(tid); sq_seq = SEQ_W'(seq);
    @(negedge clk);
    sq_valid = 1'b0;
  endtask

  task automatic t_reset;
    look(PC_L, "R1", 1'b0, 0);
    look_id(PC_S, "R1", 1'b0, 0);
  endtask

  task automatic t_fresh_pair;
    train(PC_S, PC_L);
    look_id(PC_L, "R3", 1'b1, hash(PC_L));
    look_id(PC_S, "R3", 1'b1, hash(PC_L));
    look_id(PC_S + 32'h100, "R2", 1'b1, hash(PC_L)); // same slot as PC_S
    look_id(PC_S + 32'h4, "R2", 1'b0, 0);            // neighbouring slot
  endtask

  task automatic t_insert_issue;
    look(PC_L, "R8", 1'b0, 0);       // valid set, no last store yet
    insert(PC_S, 1'b1, 10, 0);
    look(PC_L, "R6", 1'b1, 10);
    insert(PC_L, 1'b0, 20, 0);
    look(PC_L, "R7", 1'b1, 10);
    insert(PC_NO, 1'b1, 21, 0);
    look(PC_NO, "R6", 1'b0, 0);
    look(PC_L, "R6", 1'b1, 10);
    issue(PC_S, 9);
    look(PC_L, "R9", 1'b1, 10);
    issue(PC_S, 10);
    look(PC_L, "R9", 1'b0, 0);
  endtask

  task automatic t_merge;
    train(PC_S2, PC_L);              // store side untrained
    look_id(PC_S2, "R4", 1'b1, hash(PC_L));
    train(PC_S, PC_L2);              // load side untrained
    look_id(PC_L2, "R4", 1'b1, hash(PC_L));
    train(PC_S3, PC_L3);
    look_id(PC_S3, "R3", 1'b1, hash(PC_L3));
    train(PC_S3, PC_L);
    look_id(PC_S3, "R5", 1'b1, (hash(PC_L3) < hash(PC_L)) ? hash(PC_L3) : hash(PC_L));
    look_id(PC_L,  "R5", 1'b1, (hash(PC_L3) < hash(PC_L)) ? hash(PC_L3) : hash(PC_L));
  endtask

  task automatic t_squash;
    insert(PC_S, 1'b1, 30, 0);
    look(PC_L2, "R10", 1'b1, 30);
    squash(1, 5);
    look(PC_L2, "R10", 1'b1, 30);    // other thread
    squash(0, 40);
    look(PC_L2, "R10", 1'b1, 30);    // store is older than 40
    squash(0, 25);
    look(PC_L2, "R10", 1'b0, 0);
  endtask

  task automatic t_clear;
    insert(PC_S, 1'b1, 50, 0);
    look(PC_L2, "R11", 1'b1, 50);
    @(negedge clk);
    clear = 1'b1;
    ins_valid = 1'b1; ins_is_store = 1'b1; ins_pc = PC_S; ins_seq = 16'd51; ins_tid = '0;
    @(negedge clk);
    clear = 1'b0; ins_valid = 1'b0;
    look(PC_L2, "R11", 1'b0, 0);
    look_id(PC_S, "R11", 1'b0, 0);
    look_id(PC_L, "R11", 1'b0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_fresh_pair();
    t_insert_issue();
    t_merge();
    t_squash();
    t_clear();
    repeat (2) @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual running expected done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule